// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of general-purpose inputs and turns their activity into interrupt status. Every input first crosses into the local clock domain through a synchronizer chain. Each pin then gets its own trigger rule, built from three control bits. The rule can sense a level or an edge. In edge mode it can fire on one edge or on both edges. A polarity bit chooses between rising edge or high level, and falling edge or low level.

A detected event sets a sticky raw status bit for that pin. An enable vector gates the raw bits into a masked status vector, and any masked bit drives a single interrupt line. Software-side logic clears status by pulsing a clear strobe together with a bit mask. Only the pins marked 1 in that mask are cleared. Address decoding and pad control sit outside this block.

Top module: `gpio_irq_detector`

## Requirements
- R1: With the level bit at 1, a pin's raw status bit is set in every cycle where its synchronized input equals the polarity bit (1 senses a high level, 0 senses a low level). The dual-edge bit has no effect in this mode.
- R2: With the level bit and the dual-edge bit both at 0, a pin with polarity 1 sets status only on a 0-to-1 transition, and a pin with polarity 0 sets status only on a 1-to-0 transition. The opposite transition has no effect.
- R3: With the level bit at 0 and the dual-edge bit at 1, both transitions set status, whatever the polarity bit is.
- R4: An input change applied before clock edge k is first visible on the raw status output after edge k+2. It is not visible after edge k+1.
- R5: The masked status equals raw status AND the enable vector. The enable vector never changes raw status, and a change of enable shows on the masked status in the same cycle.
- R6: The interrupt output is 1 exactly when any masked status bit is 1.
- R7: A raw status bit, once set, stays set until it is cleared.
- R8: While the clear strobe is 1, every pin whose clear-mask bit is 1 has its status cleared at the next edge. Pins whose clear-mask bit is 0 keep their status.
- R9: If a pin sees an event in the same cycle as its clear, the event wins and the status bit stays set.
- R10: A level-sensed pin whose active level is still present keeps its status set across a clear. Once the level is gone, the clear takes effect.
- R11: Reset drives all status outputs to 0. No event is recognized in the first three cycles after reset is released. An input held steady through reset raises no edge afterwards.
- R12: The bank width is the parameter NUM_PINS, default 32. Bit i of every vector port belongs to pin i, including the top pin 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Asynchronous GPIO inputs |
| level_sel_i | input | NUM_PINS | 1 = level sensing, 0 = edge sensing |
| dual_edge_i | input | NUM_PINS | 1 = both edges in edge mode |
| pol_hi_i | input | NUM_PINS | 1 = rising/high, 0 = falling/low |
| enable_i | input | NUM_PINS | Per-pin interrupt enable |
| clr_i | input | 1 | Clear strobe |
| clr_mask_i | input | NUM_PINS | Write-one-to-clear pin selection |
| raw_stat_o | output | NUM_PINS | Sticky status before enable gating |
| mask_stat_o | output | NUM_PINS | Status after enable gating |
| irq_o | output | 1 | OR of masked status |

## Verification
A new event and a clear of the same pin can land in the same cycle. The bench provokes this in two ways. For an edge, it raises a rising-edge pin and asserts the clear strobe exactly at the edge where the detected event reaches the status register. For a level, it clears a high-level pin while its level is still present. In both cases the raw status must still read 1 after that edge. A second clear, made once the event is gone, must then read 0, which shows that the clear path itself works.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    TRIG_FALL  = 3'd0,
    TRIG_RISE  = 3'd1,
    TRIG_BOTH  = 3'd2,
    TRIG_LOW   = 3'd3,
    TRIG_HIGH  = 3'd4
  } trig_mode_e;

  function automatic trig_mode_e decode_mode(input logic level, input logic dual,
                                             input logic pol);
    if (level)     return pol ? TRIG_HIGH : TRIG_LOW;
    else if (dual) return TRIG_BOTH;
    else           return pol ? TRIG_RISE : TRIG_FALL;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_arm.sv
module gpio_irq_arm #(
  parameter int DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic armed_o
);

  logic [DEPTH-1:0] arm_q;

  // walks ones in until sync chain and edge history hold real input values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= '0;
    else         arm_q <= {arm_q[DEPTH-2:0], 1'b1};
  end

  assign armed_o = arm_q[DEPTH-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                armed_i,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] level_sel_i,
  input  logic [NUM_PINS-1:0] dual_edge_i,
  input  logic [NUM_PINS-1:0] pol_hi_i,
  output logic [NUM_PINS-1:0] evt_o
);

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    trig_mode_e mode;
    logic       rise, fall, hit;

    assign mode = decode_mode(level_sel_i[g], dual_edge_i[g], pol_hi_i[g]);
    assign rise = sync_i[g] & ~prev_q[g];
    assign fall = ~sync_i[g] & prev_q[g];

    always_comb begin
      unique case (mode)
        TRIG_RISE: hit = rise;
        TRIG_FALL: hit = fall;
        TRIG_BOTH: hit = rise | fall;
        TRIG_HIGH: hit = sync_i[g];
        TRIG_LOW:  hit = ~sync_i[g];
        default:   hit = 1'b0;
      endcase
    end

    assign evt_o[g] = armed_i & hit;

    a_r2_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_i && !level_sel_i[g] && evt_o[g]) |-> (sync_i[g] != $past(sync_i[g])));
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic [NUM_PINS-1:0] enable_i,
  input  logic                clr_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] raw_o,
  output logic [NUM_PINS-1:0] masked_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] raw_q;
  logic [NUM_PINS-1:0] clr_vec;

  assign clr_vec = {NUM_PINS{clr_i}} & clr_mask_i;

  // event beats clear on the same pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_vec) | evt_i;
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & enable_i;
  assign irq_o    = |masked_o;

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(raw_q) & ~$past(clr_vec)) & ~raw_q) == '0));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((raw_q & $past(clr_vec) & ~$past(evt_i)) == '0));

  a_r9_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector #(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] level_sel_i,
  input  logic [NUM_PINS-1:0] dual_edge_i,
  input  logic [NUM_PINS-1:0] pol_hi_i,
  input  logic [NUM_PINS-1:0] enable_i,
  input  logic                clr_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] raw_stat_o,
  output logic [NUM_PINS-1:0] mask_stat_o,
  output logic                irq_o
);

  localparam int ARM_DEPTH = SYNC_STAGES + 1;

  logic [NUM_PINS-1:0] sync_w;
  logic [NUM_PINS-1:0] evt_w;
  logic                armed_w;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  gpio_irq_arm #(.DEPTH(ARM_DEPTH)) u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .armed_o(armed_w)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .armed_i    (armed_w),
    .sync_i     (sync_w),
    .level_sel_i(level_sel_i),
    .dual_edge_i(dual_edge_i),
    .pol_hi_i   (pol_hi_i),
    .evt_o      (evt_w)
  );

  gpio_irq_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_w),
    .enable_i  (enable_i),
    .clr_i     (clr_i),
    .clr_mask_i(clr_mask_i),
    .raw_o     (raw_stat_o),
    .masked_o  (mask_stat_o),
    .irq_o     (irq_o)
  );

  a_r6_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((mask_stat_o != '0) && (raw_stat_o != '0)));

endmodule

// File: tb/gpio_irq_detector_test.sv
module gpio_irq_detector_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  typedef struct {
    logic [N-1:0] raw;
    logic [N-1:0] msk;
    logic         irq;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0, lvl = '0, dual = '0, pol = '0, en = '0, cmask = '0;
  logic         clr = 1'b0;
  logic [N-1:0] raw, msk;
  logic         irq;

  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detector uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .level_sel_i(lvl),
    .dual_edge_i(dual), .pol_hi_i(pol), .enable_i(en), .clr_i(clr),
    .clr_mask_i(cmask), .raw_stat_o(raw), .mask_stat_o(msk), .irq_o(irq)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver pushes; monitor pops and compares against outputs
  task automatic expect_state(logic [N-1:0] r, logic [N-1:0] e, string tag);
    exp_t it;
    it.raw = r; it.msk = r & e; it.irq = |(r & e); it.tag = tag;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic pulse_clear(logic [N-1:0] m);
    clr = 1'b1; cmask = m;
    step(1);
    clr = 1'b0; cmask = '0;
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      n_run++;
      if (raw !== it.raw || msk !== it.msk || irq !== it.irq) begin
        n_fail++;
        $display("FAIL %s: raw=%h msk=%h irq=%b expected raw=%h msk=%h irq=%b",
                 it.tag, raw, msk, irq, it.raw, it.msk, it.irq);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    // pin0 level high, pin1 level low, pin2 rise, pin3 fall, pin4 dual (pol 0),
    // pin5 rise held high through reset, pin31 rise
    lvl  = 32'h0000_0003;
    pol  = 32'hFFFF_FFE5;
    dual = 32'h0000_0010;
    en   = 32'h0000_000F;
    pins = 32'h0000_002A;
    #(CLK_PERIOD*2 + 1);
    expect_state('0, en, "R11 reset state");
    step(2);
    rst_n = 1'b1;
    step(5);
    expect_state('0, en, "R11 no false edge after reset");

    pins[2] = 1'b1;
    step(2);
    expect_state('0, en, "R4 not visible after k+1");
    step(1);
    expect_state(32'h4, en, "R2/R4 rising edge after k+2, R5/R6");

    pins[2] = 1'b0;
    step(3);
    expect_state(32'h4, en, "R2/R7 falling ignored on rise pin, sticky");

    pulse_clear(32'h4);
    expect_state('0, en, "R8 clear selected pin");

    pins[3] = 1'b0;
    step(3);
    expect_state(32'h8, en, "R2 falling edge pin");
    pulse_clear(32'h3);
    expect_state(32'h8, en, "R8 unselected pin kept");

    pins[4] = 1'b1;
    step(3);
    expect_state(32'h18, en, "R3 dual rising, R5 disabled pin");
    pulse_clear(32'h10);
    expect_state(32'h8, en, "R8 clear dual pin");
    pins[4] = 1'b0;
    step(3);
    expect_state(32'h18, en, "R3 dual falling");

    pulse_clear('1);
    expect_state('0, en, "R8/R6 clear all, irq low");

    pins[2] = 1'b1;
    step(2);
    clr = 1'b1; cmask = 32'h4;
    step(1);
    clr = 1'b0; cmask = '0;
    expect_state(32'h4, en, "R9 event wins over clear");
    pulse_clear(32'h4);
    expect_state('0, en, "R9 later clear works");

    pins[0] = 1'b1;
    step(3);
    expect_state(32'h1, en, "R1 level high");
    pulse_clear(32'h1);
    expect_state(32'h1, en, "R10 level stays across clear");
    pins[0] = 1'b0;
    step(2);
    pulse_clear(32'h1);
    expect_state('0, en, "R10 clear after level gone");

    pins[1] = 1'b0;
    step(3);
    expect_state(32'h2, en, "R1 level low");
    pins[1] = 1'b1;
    step(2);
    pulse_clear(32'h2);
    expect_state('0, en, "R1 level low released and cleared");

    en = '0;
    pins[2] = 1'b0;
    step(3);
    pins[2] = 1'b1;
    step(3);
    expect_state(32'h4, '0, "R5 enable off: raw set, masked clear");
    en = '1;
    #1;
    expect_state(32'h4, '1, "R5 enable on same cycle");

    pins[31] = 1'b1;
    step(3);
    expect_state(32'h8000_0004, '1, "R12 top pin 31");

    step(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule